// File: doc/BRIEF.md
# Windowed Signal-Absence Detector

This block watches a stream of squared input samples and decides, one window at a time, whether the channel is quiet. A gain loop elsewhere uses that decision to stop adapting while no signal is present. Each valid sample is reduced to a 16-bit magnitude slice, taken from bits 23:8 of the squared word. That slice is compared with a programmable level, and the samples that fall under the level are counted.

A window spans a programmable number of valid samples. On the last sample of a window the block compares the quiet-sample tally with a programmable minimum and sets or clears its freeze request. The request then holds until the next window ends. Both the tally and the window position restart at every boundary. A master enable forces the request low at once and keeps the block parked at the start of a fresh window.

Top module: `sig_absence_det`

## Requirements
- R1: While reset is held and right after it is released, `freeze` is low.
- R2: A valid sample counts as quiet when its slice `sq_in[23:8]`, read as unsigned, is less than `thresh`. Bits 31:24 and 7:0 of `sq_in` have no effect on the decision.
- R3: A sample whose slice equals `thresh` is not counted as quiet.
- R4: A window lasts `win_len` valid samples, and a `win_len` of 0 acts as 1. Cycles with `sq_vld` low neither advance the window nor add to the tally.
- R5: On the clock edge that accepts the last sample of a window, `freeze` becomes 1 if the quiet tally including that sample is at least `need_cnt`, and 0 otherwise. At any other time, while enabled, `freeze` keeps its value.
- R6: The quiet tally and the window position restart at each boundary, so no sample counts toward two windows.
- R7: While `en` is low, `freeze` is low in the same cycle and the window is held at its start with an empty tally. After `en` rises, `freeze` stays low until the first full window completes.
- R8: With `need_cnt` at 0, the first window boundary sets `freeze` regardless of the sample values.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| en | input | 1 | Detector enable; low forces freeze low and restarts the window |
| thresh | input | 16 | Quiet level compared with sq_in[23:8] |
| need_cnt | input | 16 | Minimum quiet samples per window to request a freeze |
| win_len | input | 16 | Window length in valid samples (0 treated as 1) |
| sq_in | input | 32 | Squared sample |
| sq_vld | input | 1 | sq_in carries a sample this cycle |
| freeze | output | 1 | Freeze request to the gain loop |

## Verification
The bench sends samples whose slice sits under the level while the bits outside 23:8 are loud, and the reverse. A design that takes the wrong bits would flip the decision. Samples exactly at the level are included, so a design that compares with less-or-equal would freeze when it should not. Each window is arranged so that its quiet samples sit at the end and the next window's sit at the start. A tally that is not cleared at the boundary would then carry over and raise a false freeze. Further tests mix invalid cycles into a window, set a zero length and a zero minimum, and toggle the enable. A design that counts idle cycles, keeps its count across a disable, or leaves the output high while disabled each fails at least one of these checks.

// File: rtl/sig_absence_det.sv
module sig_absence_det #(
  parameter int SQ_W     = 32,
  parameter int THR_W    = 16,
  parameter int SLICE_LO = 8,
  parameter int CNT_W    = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic [THR_W-1:0] thresh,
  input  logic [CNT_W-1:0] need_cnt,
  input  logic [CNT_W-1:0] win_len,
  input  logic [SQ_W-1:0]  sq_in,
  input  logic             sq_vld,
  output logic             freeze
);
  localparam int SLICE_HI = SLICE_LO + THR_W - 1;

  logic [CNT_W-1:0] win_cnt, low_cnt, last_idx;
  logic [THR_W-1:0] slice;
  logic             is_low, win_end, freeze_q;
  logic [CNT_W:0]   low_next;

  assign slice    = sq_in[SLICE_HI:SLICE_LO];
  assign is_low   = slice < thresh;
  assign last_idx = (win_len == '0) ? '0 : win_len - 1'b1;
  assign win_end  = sq_vld && (win_cnt >= last_idx);
  assign low_next = {1'b0, low_cnt} + (CNT_W+1)'(is_low);
  assign freeze   = freeze_q & en;

  always_ff @(posedge clk) begin
    if (!rst_n || !en) begin
      win_cnt  <= '0;
      low_cnt  <= '0;
      freeze_q <= 1'b0;
    end else if (sq_vld) begin
      if (win_end) begin
        win_cnt  <= '0;
        low_cnt  <= '0;
        freeze_q <= low_next >= {1'b0, need_cnt};
      end else begin
        win_cnt  <= win_cnt + 1'b1;
        low_cnt  <= low_next[CNT_W-1:0];
      end
    end
  end
endmodule

// File: rtl/sig_absence_det_chk.sv
module sig_absence_det_chk #(
  parameter int CNT_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             en,
  input logic             sq_vld,
  input logic [CNT_W-1:0] win_len,
  input logic [CNT_W-1:0] win_cnt,
  input logic [CNT_W-1:0] low_cnt,
  input logic             freeze
);
  logic at_last;
  assign at_last = sq_vld && ((win_len == '0) || (win_cnt >= win_len - 1'b1));

  always @(posedge clk) begin
    if (!rst_n) assert_reset_quiet_R1: assert (!freeze);
  end

  assert_gated_off_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !en |-> !freeze);

  assert_disabled_parked_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> (win_cnt == '0) && (low_cnt == '0));

  assert_idle_no_advance_R4: assert property (@(posedge clk) disable iff (!rst_n)
    en && !sq_vld |=> $stable(win_cnt) && $stable(low_cnt));

  assert_hold_mid_window_R5: assert property (@(posedge clk) disable iff (!rst_n)
    en && !at_last |=> $stable(freeze) || !en);

  assert_rise_needs_sample_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(freeze) |-> $past(sq_vld));

  assert_tally_bounded_R6: assert property (@(posedge clk) disable iff (!rst_n)
    low_cnt <= win_cnt);
endmodule

bind sig_absence_det sig_absence_det_chk #(.CNT_W(CNT_W)) chk_i (
  .clk(clk), .rst_n(rst_n), .en(en), .sq_vld(sq_vld), .win_len(win_len),
  .win_cnt(win_cnt), .low_cnt(low_cnt), .freeze(freeze)
);

// File: tb/sig_absence_det_tb_top.sv
module sig_absence_det_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        en = 1'b0;
  logic [15:0] thresh = 16'd100;
  logic [15:0] need_cnt = '0;
  logic [15:0] win_len = 16'd4;
  logic [31:0] sq_in = '0;
  logic        sq_vld = 1'b0;
  logic        freeze;

  int n_chk = 0;
  int n_fail = 0;

  always #4 clk = ~clk;

  sig_absence_det dut_i (
    .clk(clk), .rst_n(rst_n), .en(en), .thresh(thresh), .need_cnt(need_cnt),
    .win_len(win_len), .sq_in(sq_in), .sq_vld(sq_vld), .freeze(freeze)
  );

  localparam logic [31:0] LOW  = 32'h0000_3200;
  localparam logic [31:0] HIGH = 32'h0000_C800;
  localparam logic [31:0] EQ   = 32'h0000_6400;

  task automatic chk(string req, logic act, logic exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: freeze=%0b expected %0b at %0t", req, act, exp, $time);
    end
  endtask

  task automatic send(logic [31:0] v, logic vld = 1'b1);
    @(negedge clk);
    sq_in  = v;
    sq_vld = vld;
    @(posedge clk);
    #2;
    sq_vld = 1'b0;
  endtask

  task automatic restart(logic [15:0] wl, logic [15:0] nc);
    @(negedge clk);
    en = 1'b0; win_len = wl; need_cnt = nc;
    @(negedge clk);
    en = 1'b1;
  endtask

  task automatic t_reset;
    #2 chk("R1 during reset", freeze, 1'b0);
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    @(negedge clk) chk("R1 after reset", freeze, 1'b0);
  endtask

  task automatic t_basic;
    restart(16'd4, 16'd3);
    send(LOW); send(LOW); send(LOW);
    chk("R5 no change mid window", freeze, 1'b0);
    send(HIGH);
    chk("R5 set at boundary", freeze, 1'b1);
    send(LOW); send(HIGH); send(HIGH);
    chk("R5 held mid window", freeze, 1'b1);
    send(LOW);
    chk("R5 cleared at boundary", freeze, 1'b0);
  endtask

  task automatic t_equal;
    restart(16'd4, 16'd4);
    send(LOW); send(LOW); send(LOW); send(EQ);
    chk("R3 equal not quiet", freeze, 1'b0);
    send(LOW); send(LOW); send(LOW); send(32'h0000_6300);
    chk("R3 one under level quiet", freeze, 1'b1);
  endtask

  task automatic t_slice;
    restart(16'd4, 16'd4);
    send(32'hFF00_00FF); send(32'h0000_63FF); send(32'hAB00_3200); send(32'h8000_0001);
    chk("R2 outer bits ignored", freeze, 1'b1);
    send(32'h0001_0000); send(LOW); send(LOW); send(LOW);
    chk("R2 bit 16 in slice", freeze, 1'b0);
  endtask

  task automatic t_valid;
    restart(16'd3, 16'd3);
    send(LOW);
    for (int i = 0; i < 5; i++) send(LOW, 1'b0);
    send(LOW);
    chk("R4 idle cycles not counted", freeze, 1'b0);
    send(LOW);
    chk("R4 third valid closes window", freeze, 1'b1);
    restart(16'd0, 16'd1);
    send(LOW);
    chk("R4 zero length acts as one", freeze, 1'b1);
    send(HIGH);
    chk("R4 zero length next window", freeze, 1'b0);
  endtask

  task automatic t_restart;
    restart(16'd4, 16'd3);
    send(HIGH); send(HIGH); send(LOW); send(LOW);
    chk("R6 first window", freeze, 1'b0);
    send(LOW); send(HIGH); send(HIGH); send(HIGH);
    chk("R6 no carry across boundary", freeze, 1'b0);
  endtask

  task automatic t_enable;
    restart(16'd2, 16'd2);
    send(LOW); send(LOW);
    chk("R7 setup freeze", freeze, 1'b1);
    @(negedge clk) en = 1'b0;
    #1 chk("R7 disable forces low", freeze, 1'b0);
    send(LOW);
    chk("R7 low while disabled", freeze, 1'b0);
    @(negedge clk) en = 1'b1; win_len = 16'd4; need_cnt = 16'd3;
    #1 chk("R7 low after re-enable", freeze, 1'b0);
    send(LOW); send(HIGH); send(HIGH); send(HIGH);
    chk("R7 fresh window after enable", freeze, 1'b0);
  endtask

  task automatic t_zero_need;
    restart(16'd2, 16'd0);
    send(HIGH);
    chk("R8 before boundary", freeze, 1'b0);
    send(HIGH);
    chk("R8 zero minimum freezes", freeze, 1'b1);
  endtask

  initial begin
    #(8 * 100000);
    n_chk++; n_fail++;
    $display("FAIL watchdog: run hung, freeze=%0b expected completion", freeze);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    t_reset();
    t_basic();
    t_equal();
    t_slice();
    t_valid();
    t_restart();
    t_enable();
    t_zero_need();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule